// File: doc/BRIEF.md
# Watchdog Timer with Keyed Restart

This block is a watchdog peripheral with a small 32-bit register port. A down-counter runs while the watchdog is armed. Software keeps the system alive by writing a fixed 8-bit key to the restart register, which reloads the counter. If software stops doing that, the counter reaches zero and the block responds in one of two ways. It can drive a system reset pulse of programmable length straight away. It can also raise an interrupt first and issue the reset only if a second expiry arrives before the interrupt is serviced.

The reload value comes from a table of sixteen entries indexed by a 4-bit code. Entry n is 2^(BASE_EXP+n)-1, so the expiry period is 2^(BASE_EXP+n) clock cycles. BASE_EXP defaults to 16. Once the enable bit is set, only a system reset can clear it.

The register port is a single-cycle select/write strobe. Writes take effect at the clock edge where `bus_sel` is high. Read data appears on `bus_rdata` after that same edge and holds until the next read.

Top module: `wdog_timer`

## Requirements
- R1: After reset, the registers read as follows: control at byte address 0x00 reads 0, timeout code at 0x04 reads 0, count at 0x08 reads 2^BASE_EXP-1, and status at 0x10 reads 0. Both outputs are low.
- R2: While enabled, the counter decrements by one per cycle. When it reaches zero it expires and reloads with 2^(BASE_EXP+n)-1, where n is the code in bits 3:0 of 0x04. From a restart to the first expiry response this takes 2^(BASE_EXP+n) cycles.
- R3: A write to 0x0C reloads the counter only when bits 7:0 equal 0x76; higher bits are ignored. A write with any other low byte has no effect on the count.
- R4: Control bit 0 is the enable. Writing 1 sets it. Writing 0 does not clear it; only reset does.
- R5: While disabled, the counter holds its value and never expires.
- R6: With control bit 1 at 0, an expiry starts a reset pulse on `wdt_rst_o` one cycle later, and no interrupt is raised.
- R7: The reset pulse lasts exactly 2^(k+1) cycles, where k is control bits 4:2. A new expiry during a pulse does not extend it.
- R8: With control bit 1 at 1, an expiry with no interrupt pending sets the interrupt and reloads the counter. An expiry while the interrupt is pending starts the reset pulse.
- R9: Bit 0 of the status register at 0x10 shows the pending interrupt, which is also driven on `wdt_irq_o`. A read of 0x14 returns the pending flag in bit 0 and clears it.
- R10: A correct key write to 0x0C also clears a pending interrupt.
- R11: A write to the timeout code does not change the running count. The new code is used at the next reload, whether that reload comes from a restart or from an expiry.
- R12: A read of 0x08 returns the counter value present at the clock edge of the read, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset, asynchronous |
| bus_sel | input | 1 | Access strobe for one cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| wdt_rst_o | output | 1 | System reset pulse, active high |
| wdt_irq_o | output | 1 | Pending watchdog interrupt |

## Verification
The expiry path is measured cycle by cycle from a restart for several timeout codes and pulse lengths. This separates an off-by-one in the reload value from an error in the pulse counter. Restart writes are tried with the key in the low byte plus unrelated upper bits, and with a wrong low byte, to show that only bits 7:0 are decoded. In interrupt-first mode, three sequences tell the cases apart:
- letting the interrupt go unserviced, which ends in a reset;
- clearing it by a read of the clear register;
- clearing it with the restart key.

Each of the last two leads to a fresh interrupt, not a reset. A timeout code written mid-count shows up only in the period after the next reload.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   // register byte offsets
   localparam int unsigned OFS_CTRL    = 'h00;
   localparam int unsigned OFS_TMO     = 'h04;
   localparam int unsigned OFS_COUNT   = 'h08;
   localparam int unsigned OFS_KICK    = 'h0C;
   localparam int unsigned OFS_STATUS  = 'h10;
   localparam int unsigned OFS_IRQCLR  = 'h14;

   // restart key, decoded from bits 7:0 only
   localparam logic [7:0] KICK_KEY = 8'h76;

   typedef enum logic {
      RESP_RESET     = 1'b0,
      RESP_IRQ_FIRST = 1'b1
   } resp_mode_e;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
   import wdog_pkg::*;
#(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned CODE_W = 4,
   parameter int unsigned PLEN_W = 3,
   parameter int unsigned CNT_W  = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [CNT_W-1:0]  cnt_val,
   input  logic              irq_set,
   output logic              arm_q,
   output resp_mode_e        mode_q,
   output logic [PLEN_W-1:0] plen_q,
   output logic [CODE_W-1:0] code_q,
   output logic              kick_ok,
   output logic              irq_q
);

   localparam int unsigned PLEN_LSB = 2;
   localparam int unsigned CTRL_W   = PLEN_LSB + PLEN_W;

   logic        is_wr;
   logic        is_rd;
   logic        wr_ctrl;
   logic        wr_tmo;
   logic        wr_kick;
   logic        rd_irqclr;
   logic [31:0] rd_mux;
   logic        unused_wdata;

   assign is_wr     = bus_sel &&  bus_wr;
   assign is_rd     = bus_sel && !bus_wr;
   assign wr_ctrl   = is_wr && (bus_addr == ADDR_W'(OFS_CTRL));
   assign wr_tmo    = is_wr && (bus_addr == ADDR_W'(OFS_TMO));
   assign wr_kick   = is_wr && (bus_addr == ADDR_W'(OFS_KICK));
   assign rd_irqclr = is_rd && (bus_addr == ADDR_W'(OFS_IRQCLR));
   assign kick_ok   = wr_kick && (bus_wdata[7:0] == KICK_KEY);

   assign unused_wdata = ^bus_wdata[31:8];

   // control: enable is sticky, mode and pulse length are free to change
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_q  <= 1'b0;
         mode_q <= RESP_RESET;
         plen_q <= '0;
      end else if (wr_ctrl) begin
         arm_q  <= arm_q | bus_wdata[0];
         mode_q <= resp_mode_e'(bus_wdata[1]);
         plen_q <= bus_wdata[PLEN_LSB +: PLEN_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      code_q <= '0;
      else if (wr_tmo) code_q <= bus_wdata[CODE_W-1:0];
   end

   // pending interrupt: a new expiry wins over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      irq_q <= 1'b0;
      else if (irq_set)                irq_q <= 1'b1;
      else if (kick_ok || rd_irqclr)   irq_q <= 1'b0;
   end

   always_comb begin
      rd_mux = '0;
      case (bus_addr)
         ADDR_W'(OFS_CTRL):   rd_mux[CTRL_W-1:0] = {plen_q, mode_q, arm_q};
         ADDR_W'(OFS_TMO):    rd_mux[CODE_W-1:0] = code_q;
         ADDR_W'(OFS_COUNT):  rd_mux[CNT_W-1:0]  = cnt_val;
         ADDR_W'(OFS_STATUS): rd_mux[0]          = irq_q;
         ADDR_W'(OFS_IRQCLR): rd_mux[0]          = irq_q;
         default:             rd_mux             = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     bus_rdata <= '0;
      else if (is_rd) bus_rdata <= rd_mux;
   end

   AST_ARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n) arm_q |=> arm_q); // R4
   AST_IRQCLR_READ: assert property (@(posedge clk) disable iff (!rst_n) (rd_irqclr && !irq_set) |=> !irq_q); // R9
   AST_KICK_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n) (kick_ok && !irq_set) |=> !irq_q); // R10

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
   parameter int unsigned BASE_EXP = 16,
   parameter int unsigned CODE_W   = 4,
   parameter int unsigned CNT_W    = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm,
   input  logic              kick,
   input  logic [CODE_W-1:0] code,
   output logic [CNT_W-1:0]  cnt_q,
   output logic              expire
);

   localparam int unsigned NUM_CODES = 1 << CODE_W;

   logic [CNT_W-1:0] reload_tbl [NUM_CODES];

   // entry g holds 2^(BASE_EXP+g)-1
   for (genvar g = 0; g < NUM_CODES; g++) begin : g_reload
      assign reload_tbl[g] = {CNT_W{1'b1}} >> (CNT_W - BASE_EXP - g);
   end

   // a restart in the same cycle as a zero count pre-empts the expiry
   assign expire = arm && (cnt_q == '0) && !kick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= reload_tbl[0];
      else if (kick || expire)  cnt_q <= reload_tbl[code];
      else if (arm)             cnt_q <= cnt_q - 1'b1;
   end

   AST_HOLD_DISARMED: assert property (@(posedge clk) disable iff (!rst_n) (!arm && !kick) |=> $stable(cnt_q)); // R5
   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) (arm && !kick && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1); // R2
   AST_KICK_RELOAD: assert property (@(posedge clk) disable iff (!rst_n) kick |=> cnt_q == reload_tbl[$past(code)]); // R3

endmodule

// File: rtl/wdog_rst_pulse.sv
module wdog_rst_pulse #(
   parameter int unsigned PLEN_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig,
   input  logic [PLEN_W-1:0] plen,
   output logic              pulse_q
);

   localparam int unsigned LEN_W = 1 << PLEN_W;

   logic [LEN_W-1:0] left_q;
   logic [LEN_W-1:0] len_m1;

   // 2^(plen+1)-1: since LEN_W-1 is all ones in PLEN_W bits, the shift is ~plen
   assign len_m1 = {LEN_W{1'b1}} >> (~plen);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse_q <= 1'b0;
         left_q  <= '0;
      end else if (pulse_q) begin
         if (left_q == '0) pulse_q <= 1'b0;
         else              left_q  <= left_q - 1'b1;
      end else if (trig) begin
         pulse_q <= 1'b1;
         left_q  <= len_m1;
      end
   end

   AST_PULSE_MIN_LEN: assert property (@(posedge clk) disable iff (!rst_n) $rose(pulse_q) |=> pulse_q); // R7

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
   import wdog_pkg::*;
#(
   parameter int unsigned ADDR_W   = 5,
   parameter int unsigned BASE_EXP = 16,
   parameter int unsigned CODE_W   = 4,
   parameter int unsigned PLEN_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              wdt_rst_o,
   output logic              wdt_irq_o
);

   localparam int unsigned CNT_W = BASE_EXP + (1 << CODE_W) - 1;

   if (CNT_W > 32) begin : g_bad_cnt_w
      $error("wdog_timer: BASE_EXP + 2^CODE_W - 1 exceeds 32 bits");
   end
   if (ADDR_W < 5) begin : g_bad_addr_w
      $error("wdog_timer: ADDR_W too small for register map");
   end
   if (PLEN_LSB_FIT(PLEN_W) > 32) begin : g_bad_plen_w
      $error("wdog_timer: pulse length field does not fit control register");
   end

   function automatic int unsigned PLEN_LSB_FIT(input int unsigned w);
      return 2 + w;
   endfunction

   logic              arm;
   resp_mode_e        mode;
   logic [PLEN_W-1:0] plen;
   logic [CODE_W-1:0] code;
   logic              kick;
   logic              irq_pend;
   logic [CNT_W-1:0]  cnt;
   logic              expire;
   logic              irq_set;
   logic              rst_trig;

   assign irq_set  = expire && (mode == RESP_IRQ_FIRST) && !irq_pend;
   assign rst_trig = expire && ((mode == RESP_RESET) || irq_pend);

   wdog_regs #(
      .ADDR_W (ADDR_W),
      .CODE_W (CODE_W),
      .PLEN_W (PLEN_W),
      .CNT_W  (CNT_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .cnt_val   (cnt),
      .irq_set   (irq_set),
      .arm_q     (arm),
      .mode_q    (mode),
      .plen_q    (plen),
      .code_q    (code),
      .kick_ok   (kick),
      .irq_q     (irq_pend)
   );

   wdog_counter #(
      .BASE_EXP (BASE_EXP),
      .CODE_W   (CODE_W),
      .CNT_W    (CNT_W)
   ) u_counter (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm    (arm),
      .kick   (kick),
      .code   (code),
      .cnt_q  (cnt),
      .expire (expire)
   );

   wdog_rst_pulse #(
      .PLEN_W (PLEN_W)
   ) u_pulse (
      .clk     (clk),
      .rst_n   (rst_n),
      .trig    (rst_trig),
      .plen    (plen),
      .pulse_q (wdt_rst_o)
   );

   assign wdt_irq_o = irq_pend;

   AST_DIRECT_RESET: assert property (@(posedge clk) disable iff (!rst_n) (expire && mode == RESP_RESET && !wdt_rst_o) |=> wdt_rst_o); // R6
   AST_FIRST_EXPIRY_IRQ: assert property (@(posedge clk) disable iff (!rst_n) (expire && mode == RESP_IRQ_FIRST && !wdt_irq_o) |=> wdt_irq_o); // R8
   AST_SECOND_EXPIRY_RST: assert property (@(posedge clk) disable iff (!rst_n) (expire && mode == RESP_IRQ_FIRST && wdt_irq_o && !wdt_rst_o) |=> wdt_rst_o); // R8
   AST_DISARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !arm |-> !expire); // R5

endmodule

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb;

   localparam int unsigned BEXP = 4;
   localparam int unsigned TMO0 = (1 << BEXP) - 1;

   localparam logic [4:0] A_CTRL   = 5'h00;
   localparam logic [4:0] A_TMO    = 5'h04;
   localparam logic [4:0] A_COUNT  = 5'h08;
   localparam logic [4:0] A_KICK   = 5'h0C;
   localparam logic [4:0] A_STATUS = 5'h10;
   localparam logic [4:0] A_IRQCLR = 5'h14;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        bus_sel;
   logic        bus_wr;
   logic [4:0]  bus_addr;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata;
   logic        wdt_rst_o;
   logic        wdt_irq_o;

   int n_checks = 0;
   int n_errors = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   wdog_timer #(.BASE_EXP(BEXP)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .wdt_rst_o (wdt_rst_o),
      .wdt_irq_o (wdt_irq_o)
   );

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
      end
   endtask

   task automatic do_reset();
      bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b0;
      d = bus_rdata;
   endtask

   // waits until wdt_rst_o is high, counting negedges from n
   task automatic wait_rst(inout int n, input int lim);
      while (!wdt_rst_o && n < lim) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic t_reset_state();
      logic [31:0] d;
      do_reset();
      check("R1", "rst_o after reset", 32'(wdt_rst_o), 0);
      check("R1", "irq_o after reset", 32'(wdt_irq_o), 0);
      bus_read(A_CTRL, d);   check("R1", "control", d, 0);
      bus_read(A_TMO, d);    check("R1", "timeout code", d, 0);
      bus_read(A_COUNT, d);  check("R1", "count", d, TMO0);
      bus_read(A_STATUS, d); check("R1", "status", d, 0);
   endtask

   task automatic t_disarmed();
      logic [31:0] d;
      int seen = 0;
      do_reset();
      bus_write(A_TMO, 32'h2);
      bus_write(A_KICK, 32'h76);
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (wdt_rst_o || wdt_irq_o) seen++;
      end
      check("R5", "responses while disarmed", seen, 0);
      bus_read(A_COUNT, d);
      check("R5", "count held while disarmed", d, (1 << (BEXP + 2)) - 1);
   endtask

   task automatic t_period(input int code, input int k);
      int n = 0;
      int len = 0;
      do_reset();
      bus_write(A_TMO, 32'(code));
      bus_write(A_CTRL, 32'(1 | (k << 2)));
      bus_write(A_KICK, 32'h76);
      wait_rst(n, 5000);
      check("R2", $sformatf("cycles to expiry code %0d", code), n, 1 << (BEXP + code));
      check("R6", "no irq in direct mode", 32'(wdt_irq_o), 0);
      while (wdt_rst_o && len < 1000) begin
         @(negedge clk);
         len++;
      end
      check("R7", $sformatf("pulse length k=%0d", k), len, 1 << (k + 1));
   endtask

   task automatic t_key(input logic [31:0] val, input bit good);
      int n = 0;
      do_reset();
      bus_write(A_CTRL, 32'h1);
      bus_write(A_KICK, 32'h76);
      repeat (6) @(negedge clk);
      bus_write(A_KICK, val);
      n = 7;
      wait_rst(n, 500);
      check("R3", $sformatf("expiry index after restart write 0x%0h", val), n,
            good ? (7 + (1 << BEXP)) : (1 << BEXP));
   endtask

   task automatic t_sticky();
      logic [31:0] d;
      do_reset();
      bus_write(A_CTRL, 32'h1);
      bus_write(A_CTRL, 32'h0);
      bus_read(A_CTRL, d);
      check("R4", "enable after writing 0", d, 32'h1);
      bus_write(A_CTRL, 32'h2);
      bus_read(A_CTRL, d);
      check("R4", "enable kept, mode updated", d, 32'h3);
   endtask

   task automatic t_irq_then_reset();
      logic [31:0] d;
      int n = 0;
      int irq_at = -1;
      do_reset();
      bus_write(A_CTRL, 32'h3);
      bus_write(A_KICK, 32'h76);
      while (!wdt_rst_o && n < 500) begin
         @(negedge clk);
         n++;
         if (wdt_irq_o && irq_at < 0) irq_at = n;
      end
      check("R8", "first expiry raises irq", irq_at, 1 << BEXP);
      check("R8", "second expiry resets", n, 2 << BEXP);
      bus_read(A_STATUS, d);
      check("R9", "status bit while pending", d, 1);
   endtask

   task automatic t_irq_clear_read();
      logic [31:0] d;
      int n = 0;
      do_reset();
      bus_write(A_CTRL, 32'h3);
      bus_write(A_KICK, 32'h76);
      while (!wdt_irq_o && n < 500) begin
         @(negedge clk);
         n++;
      end
      check("R8", "irq index", n, 1 << BEXP);
      bus_read(A_IRQCLR, d);
      check("R9", "clear read returns pending", d, 1);
      check("R9", "irq_o after clear read", 32'(wdt_irq_o), 0);
      bus_read(A_IRQCLR, d);
      check("R9", "second clear read", d, 0);
      bus_read(A_STATUS, d);
      check("R9", "status after clear", d, 0);
      n += 3;
      while (!wdt_irq_o && !wdt_rst_o && n < 500) begin
         @(negedge clk);
         n++;
      end
      check("R9", "next expiry raises irq again", n, 2 << BEXP);
      check("R9", "no reset after serviced irq", 32'(wdt_rst_o), 0);
   endtask

   task automatic t_irq_clear_key();
      int n = 0;
      do_reset();
      bus_write(A_CTRL, 32'h3);
      bus_write(A_KICK, 32'h76);
      while (!wdt_irq_o && n < 500) begin
         @(negedge clk);
         n++;
      end
      bus_write(A_KICK, 32'h76);
      n++;
      check("R10", "irq_o after key write", 32'(wdt_irq_o), 0);
      while (!wdt_irq_o && !wdt_rst_o && n < 500) begin
         @(negedge clk);
         n++;
      end
      check("R10", "irq again after reload", n, (1 << BEXP) + 1 + (1 << BEXP));
      check("R10", "no reset", 32'(wdt_rst_o), 0);
   endtask

   task automatic t_defer_code();
      int n = 0;
      do_reset();
      bus_write(A_CTRL, 32'h1);
      bus_write(A_KICK, 32'h76);
      repeat (3) @(negedge clk);
      bus_write(A_TMO, 32'h1);
      n = 4;
      wait_rst(n, 500);
      check("R11", "running count unaffected", n, 1 << BEXP);
      while (wdt_rst_o && n < 500) begin
         @(negedge clk);
         n++;
      end
      wait_rst(n, 500);
      check("R11", "new code used at reload", n, (1 << BEXP) + (2 << BEXP));
   endtask

   task automatic t_count_read();
      logic [31:0] d;
      do_reset();
      bus_write(A_TMO, 32'h1);
      bus_write(A_CTRL, 32'h1);
      bus_write(A_KICK, 32'h176);
      repeat (4) @(negedge clk);
      bus_read(A_COUNT, d);
      check("R12", "count readout", d, (2 << BEXP) - 1 - 4);
   endtask

   initial begin
      t_reset_state();
      t_disarmed();
      t_period(0, 0);
      t_period(2, 3);
      t_period(1, 7);
      t_key(32'h1A5, 1'b0);
      t_key(32'h75, 1'b0);
      t_key(32'hABC176, 1'b1);
      t_sticky();
      t_irq_then_reset();
      t_irq_clear_read();
      t_irq_clear_key();
      t_defer_code();
      t_count_read();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog R1..: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
         $finish;
      end
   end

endmodule